// File: doc/BRIEF.md
# Sub-word SIMD add register file with element-width writeback

This block holds a small file of 64-bit integer registers and performs one packed add per cycle between two of them. A two-bit width code splits each 64-bit operand into lanes of 8, 16, 32 or 64 bits. Every lane adds on its own and wraps without a carry into its neighbour. The result is then shaped for the destination and written on the next rising clock edge.

A scalar destination takes a number of packed low elements equal to the multiplier. With one element, an integer result is widened by its type. With more than one, the bits above the packed elements are zero-filled, or set to ones when the floating-point boxing mode is selected. A vector destination takes vector length × multiplier elements. Only those bytes are replaced and every other byte keeps its old value. A source flagged scalar in a vector operation supplies its element 0 to every lane.

A load port and a read port exist so a bench can seed and inspect registers. All pins are plain control or data pins sampled on the clock. There is no valid/ready stream and no back-pressure: an operation presented with `op_en` high is taken in that cycle.

Top module: `subword_add_rf`

## Requirements
- R1: Register 0 reads as all zeros wherever it is read: as either source, whatever that source's vector flag says, and on the read port.
- R2: Writes aimed at register 0, whether from an operation or from the load port, are dropped.
- R3: With `rst` high at a rising edge, every register is cleared to zero. A write lands at the rising edge where `op_en` or `load_en` is high, and the read port shows it combinationally after that edge.
- R4: Width code 00 selects 64-bit, 01 32-bit, 10 16-bit and 11 8-bit elements. Each lane sum wraps modulo its width, and no carry crosses a lane boundary.
- R5: Scalar destination, integer mode (`box_ones`=0), element count 1: an 8-bit result is zero-extended, a 16-bit or 32-bit result is sign-extended from its top bit, and a 64-bit result is written whole. A multiplier value of 0 counts as 1.
- R6: Scalar destination, boxing mode (`box_ones`=1): every bit above the written elements is set to one, whatever the multiplier.
- R7: Scalar destination, multiplier m > 1, integer mode: the low m elements of each source are added lane by lane and packed at the bottom, and all bits above them are zero with no sign extension. Example: 8-bit, m=3, 0x01820304 + 0x11223344 gives 0xA43648.
- R8: The scalar element count is capped at the lanes that fit in 64 bits. A packed result never changes any register other than the destination.
- R9: Vector destination: count = `vec_len` × multiplier, capped at the lane count. Only the bytes of those elements change and all other bytes keep their contents. With `vec_len` = 0 nothing is written.
- R10: A `load_en` write of `load_data` to `load_idx` takes precedence. Any operation presented in the same cycle is discarded.
- R11: In a vector-destination operation, a source whose vector flag is 0 supplies its element 0 to every lane. A source flagged vector supplies lane by lane. For a scalar destination, both sources supply lane by lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_en | input | 1 | Perform and write back the operation this cycle |
| src_a_idx | input | 5 | First source register number |
| src_a_vec | input | 1 | First source is a vector operand |
| src_b_idx | input | 5 | Second source register number |
| src_b_vec | input | 1 | Second source is a vector operand |
| dst_idx | input | 5 | Destination register number |
| dst_vec | input | 1 | Destination is a vector |
| ew_sel | input | 2 | Element width code (00=64, 01=32, 10=16, 11=8) |
| mul_cnt | input | 4 | Element multiplier (0 treated as 1) |
| vec_len | input | 4 | Vector length for vector destinations |
| box_ones | input | 1 | Floating-point boxing fill mode for scalar results |
| load_en | input | 1 | Direct register load strobe |
| load_idx | input | 5 | Register number to load |
| load_data | input | 64 | Value to load |
| peek_idx | input | 5 | Register number shown on `peek_data` |
| peek_data | output | 64 | Combinational contents of register `peek_idx` |

## Verification
Each operation or load shows up one rising edge after its inputs are applied. The read port is combinational, so a result can be read as soon as that edge has passed. The bench therefore drives inputs at a falling edge and lets the next rising edge commit them. At the following falling edge it points `peek_idx` at the register of interest and samples a moment later, never at a rising edge. Expected register images come from a bench model that applies the writeback rules element by element. Directed cases also compare against hand-worked literals.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef enum logic [1:0] {
    EW_64 = 2'b00,
    EW_32 = 2'b01,
    EW_16 = 2'b10,
    EW_8  = 2'b11
  } ew_e;
endpackage

// File: rtl/sw_regfile.sv
module sw_regfile #(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  parameter int NRD  = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [IW-1:0]             waddr,
  input  logic [XLEN-1:0]           wdata,
  input  logic [NRD-1:0][IW-1:0]    raddr,
  output logic [NRD-1:0][XLEN-1:0]  rdata
);
  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we && waddr != '0) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = (raddr[p] == '0) ? '0 : mem[raddr[p]];
  end
endmodule

// File: rtl/sw_lane_add.sv
module sw_lane_add #(
  parameter int XLEN = 64,
  localparam int NB  = XLEN / 8,
  localparam int BW  = $clog2(NB) + 1
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [1:0]      ew,
  output logic [XLEN-1:0] sum
);
  logic [BW-1:0] eb;
  logic [NB-1:0] cy;

  assign eb    = BW'(NB) >> ew;
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic cin;
    // a lane starts wherever the byte index is a multiple of the element size
    assign cin = ((BW'(i) & (eb - BW'(1))) == '0) ? 1'b0 : cy[i];
    if (i < NB - 1) begin : g_mid
      logic [8:0] s;
      assign s            = {1'b0, a[8*i +: 8]} + {1'b0, b[8*i +: 8]} + {8'd0, cin};
      assign sum[8*i +: 8] = s[7:0];
      assign cy[i+1]       = s[8];
    end else begin : g_last
      assign sum[8*i +: 8] = a[8*i +: 8] + b[8*i +: 8] + {7'd0, cin};
    end
  end
endmodule

// File: rtl/sw_wb_format.sv
module sw_wb_format
  import sw_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int MUL_W = 4,
  parameter int VL_W  = 4,
  localparam int NB   = XLEN / 8,
  localparam int BW   = $clog2(NB) + 1,
  localparam int CW   = MUL_W + VL_W
) (
  input  logic [XLEN-1:0]  sum_i,
  input  logic [XLEN-1:0]  old_i,
  input  logic [1:0]       ew,
  input  logic [MUL_W-1:0] mul,
  input  logic [VL_W-1:0]  vl,
  input  logic             dvec,
  input  logic             box,
  output logic [XLEN-1:0]  wdata,
  output logic             wr_any
);
  logic [BW-1:0]    eb, lanes, cnt, nbytes;
  logic [MUL_W-1:0] mul_eff;
  logic [CW-1:0]    cnt_raw;
  logic             sgn, ext_sign;

  assign eb       = BW'(NB) >> ew;
  assign lanes    = BW'(NB) / eb;
  assign mul_eff  = (mul == '0) ? MUL_W'(1) : mul;
  assign cnt_raw  = dvec ? (CW'(vl) * CW'(mul_eff)) : CW'(mul_eff);
  assign cnt      = (cnt_raw > CW'(lanes)) ? lanes : cnt_raw[BW-1:0];
  assign nbytes   = cnt * eb;
  assign wr_any   = (nbytes != '0);
  assign ext_sign = (mul_eff == MUL_W'(1)) && (ew == EW_16 || ew == EW_32);

  always_comb begin
    sgn = 1'b0;
    for (int i = 0; i < NB; i++)
      if (BW'(i + 1) == nbytes) sgn = sum_i[8*i + 7];
  end

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      if (BW'(i) < nbytes)  wdata[8*i +: 8] = sum_i[8*i +: 8];
      else if (dvec)        wdata[8*i +: 8] = old_i[8*i +: 8];
      else if (box)         wdata[8*i +: 8] = 8'hFF;
      else if (ext_sign)    wdata[8*i +: 8] = {8{sgn}};
      else                  wdata[8*i +: 8] = 8'h00;
    end
  end
endmodule

// File: rtl/subword_add_rf.sv
module subword_add_rf #(
  parameter int XLEN  = 64,
  parameter int NREG  = 32,
  parameter int MUL_W = 4,
  parameter int VL_W  = 4,
  localparam int IW   = $clog2(NREG),
  localparam int NB   = XLEN / 8,
  localparam int BW   = $clog2(NB) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_en,
  input  logic [IW-1:0]    src_a_idx,
  input  logic             src_a_vec,
  input  logic [IW-1:0]    src_b_idx,
  input  logic             src_b_vec,
  input  logic [IW-1:0]    dst_idx,
  input  logic             dst_vec,
  input  logic [1:0]       ew_sel,
  input  logic [MUL_W-1:0] mul_cnt,
  input  logic [VL_W-1:0]  vec_len,
  input  logic             box_ones,
  input  logic             load_en,
  input  logic [IW-1:0]    load_idx,
  input  logic [XLEN-1:0]  load_data,
  input  logic [IW-1:0]    peek_idx,
  output logic [XLEN-1:0]  peek_data
);
  logic [3:0][IW-1:0]   raddr;
  logic [3:0][XLEN-1:0] rdata;
  logic [XLEN-1:0]      a_bc, b_bc, sum, fmt_data, wdata;
  logic [IW-1:0]        waddr;
  logic [BW-1:0]        eb;
  logic                 we, wr_any, bc_a, bc_b;

  assign raddr = {peek_idx, dst_idx, src_b_idx, src_a_idx};

  sw_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(4)) u_rf (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );

  // a scalar source feeding a vector destination repeats its element 0
  assign eb   = BW'(NB) >> ew_sel;
  assign bc_a = dst_vec && !src_a_vec;
  assign bc_b = dst_vec && !src_b_vec;

  always_comb begin
    a_bc = rdata[0];
    b_bc = rdata[1];
    for (int i = 0; i < NB; i++) begin
      for (int j = 0; j < NB; j++) begin
        if (BW'(j) == (BW'(i) & (eb - BW'(1)))) begin
          if (bc_a) a_bc[8*i +: 8] = rdata[0][8*j +: 8];
          if (bc_b) b_bc[8*i +: 8] = rdata[1][8*j +: 8];
        end
      end
    end
  end

  sw_lane_add #(.XLEN(XLEN)) u_add (
    .a(a_bc), .b(b_bc), .ew(ew_sel), .sum(sum)
  );

  sw_wb_format #(.XLEN(XLEN), .MUL_W(MUL_W), .VL_W(VL_W)) u_fmt (
    .sum_i(sum), .old_i(rdata[2]), .ew(ew_sel), .mul(mul_cnt), .vl(vec_len),
    .dvec(dst_vec), .box(box_ones), .wdata(fmt_data), .wr_any(wr_any)
  );

  assign we        = load_en || (op_en && wr_any);
  assign waddr     = load_en ? load_idx  : dst_idx;
  assign wdata     = load_en ? load_data : fmt_data;
  assign peek_data = rdata[3];
endmodule

// File: rtl/sw_rf_checker.sv
module sw_rf_checker #(
  parameter int XLEN  = 64,
  parameter int IW    = 5,
  parameter int MUL_W = 4,
  parameter int VL_W  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             op_en,
  input logic             load_en,
  input logic [IW-1:0]    load_idx,
  input logic [XLEN-1:0]  load_data,
  input logic [IW-1:0]    dst_idx,
  input logic             dst_vec,
  input logic [1:0]       ew_sel,
  input logic [MUL_W-1:0] mul_cnt,
  input logic [VL_W-1:0]  vec_len,
  input logic             box_ones,
  input logic [IW-1:0]    peek_idx,
  input logic [XLEN-1:0]  peek_data
);
  assert_x0_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (peek_idx == '0) |-> (peek_data == '0));

  assert_load_lands_R10: assert property (@(posedge clk) disable iff (rst)
    (load_en && load_idx != '0 && peek_idx == load_idx)
    |=> (peek_idx != $past(peek_idx)) || (peek_data == $past(load_data)));

  assert_vec_len0_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    (op_en && !load_en && dst_vec && vec_len == '0 && peek_idx == dst_idx)
    |=> (peek_idx != $past(peek_idx)) || (peek_data == $past(peek_data)));

  assert_byte_zero_ext_R5: assert property (@(posedge clk) disable iff (rst)
    (op_en && !load_en && !dst_vec && !box_ones && ew_sel == 2'b11 &&
     mul_cnt <= MUL_W'(1) && dst_idx != '0 && peek_idx == dst_idx)
    |=> (peek_idx != $past(peek_idx)) || (peek_data[XLEN-1:8] == '0));

  assert_half_boxed_R6: assert property (@(posedge clk) disable iff (rst)
    (op_en && !load_en && !dst_vec && box_ones && ew_sel == 2'b10 &&
     mul_cnt <= MUL_W'(1) && dst_idx != '0 && peek_idx == dst_idx)
    |=> (peek_idx != $past(peek_idx)) || (peek_data[XLEN-1:16] == '1));
endmodule

bind subword_add_rf sw_rf_checker #(
  .XLEN(XLEN), .IW(IW), .MUL_W(MUL_W), .VL_W(VL_W)
) u_chk (
  .clk(clk), .rst(rst), .op_en(op_en), .load_en(load_en), .load_idx(load_idx),
  .load_data(load_data), .dst_idx(dst_idx), .dst_vec(dst_vec), .ew_sel(ew_sel),
  .mul_cnt(mul_cnt), .vec_len(vec_len), .box_ones(box_ones),
  .peek_idx(peek_idx), .peek_data(peek_data)
);

// File: tb/sim_subword_add_rf.sv
module sim_subword_add_rf;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_en = 1'b0;
  logic [4:0]  src_a_idx = '0, src_b_idx = '0, dst_idx = '0;
  logic        src_a_vec = 1'b0, src_b_vec = 1'b0, dst_vec = 1'b0;
  logic [1:0]  ew_sel = '0;
  logic [3:0]  mul_cnt = '0, vec_len = '0;
  logic        box_ones = 1'b0;
  logic        load_en = 1'b0;
  logic [4:0]  load_idx = '0;
  logic [63:0] load_data = '0;
  logic [4:0]  peek_idx = '0;
  logic [63:0] peek_data;

  int checks = 0;
  int errors = 0;
  logic [63:0] model [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  subword_add_rf u0 (
    .clk(clk), .rst(rst), .op_en(op_en),
    .src_a_idx(src_a_idx), .src_a_vec(src_a_vec),
    .src_b_idx(src_b_idx), .src_b_vec(src_b_vec),
    .dst_idx(dst_idx), .dst_vec(dst_vec), .ew_sel(ew_sel),
    .mul_cnt(mul_cnt), .vec_len(vec_len), .box_ones(box_ones),
    .load_en(load_en), .load_idx(load_idx), .load_data(load_data),
    .peek_idx(peek_idx), .peek_data(peek_data)
  );

  function automatic logic [63:0] ref_op(
    logic [63:0] a, logic [63:0] b, logic [63:0] old, logic [1:0] ew,
    logic [3:0] mul, logic [3:0] vl, logic av, logic bv, logic dv, logic fp);
    int w, lanes, m, cnt, nb, sa, sb;
    logic [63:0] lm, r, s, hi;
    w = 64 >> ew;
    lanes = 64 / w;
    m = (mul == 0) ? 1 : int'(mul);
    cnt = dv ? int'(vl) * m : m;
    if (cnt > lanes) cnt = lanes;
    lm = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    r = dv ? old : 64'd0;
    for (int e = 0; e < cnt; e++) begin
      sa = (dv && !av) ? 0 : e * w;
      sb = (dv && !bv) ? 0 : e * w;
      s = ((a >> sa) + (b >> sb)) & lm;
      r = (r & ~(lm << (e * w))) | (s << (e * w));
    end
    nb = cnt * w;
    if (!dv && nb < 64) begin
      hi = ~64'd0 << nb;
      if (fp) r = r | hi;
      else if (m == 1 && (w == 16 || w == 32) && r[nb-1]) r = r | hi;
    end
    return r;
  endfunction

  task automatic check_reg(input logic [4:0] idx, input logic [63:0] exp, input string tag);
    peek_idx = idx;
    #1;
    checks++;
    if (peek_data !== exp) begin
      errors++;
      $display("FAIL %s: reg %0d actual %h expected %h", tag, idx, peek_data, exp);
    end
  endtask

  task automatic do_load(input logic [4:0] idx, input logic [63:0] val);
    @(negedge clk);
    load_en = 1'b1; load_idx = idx; load_data = val;
    @(posedge clk);
    @(negedge clk);
    load_en = 1'b0;
    if (idx != 0) model[idx] = val;
  endtask

  task automatic do_op(input logic [4:0] a, input logic av, input logic [4:0] b,
                       input logic bv, input logic [4:0] d, input logic dv,
                       input logic [1:0] ew, input logic [3:0] mul,
                       input logic [3:0] vl, input logic fp, input string tag);
    logic [63:0] e;
    @(negedge clk);
    src_a_idx = a; src_a_vec = av; src_b_idx = b; src_b_vec = bv;
    dst_idx = d; dst_vec = dv; ew_sel = ew; mul_cnt = mul; vec_len = vl;
    box_ones = fp; op_en = 1'b1;
    e = ref_op(model[a], model[b], model[d], ew, mul, vl, av, bv, dv, fp);
    @(posedge clk);
    @(negedge clk);
    op_en = 1'b0;
    if (d != 0) model[d] = e;
    check_reg(d, model[d], tag);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R3: cleared after reset
    check_reg(5'd1, 64'd0, "R3");
    check_reg(5'd31, 64'd0, "R3");

    do_load(5'd16, 64'h0000_0000_0182_0304);
    do_load(5'd20, 64'h0000_0000_1122_3344);
    do_load(5'd12, 64'h0123_4567_89AB_CDEF);
    do_load(5'd13, 64'hDEAD_BEEF_CAFE_F00D);
    check_reg(5'd12, 64'h0123_4567_89AB_CDEF, "R10");

    // R7: worked packed case
    do_op(5'd16, 1'b0, 5'd20, 1'b0, 5'd12, 1'b0, 2'b11, 4'd3, 4'd0, 1'b0, "R7");
    check_reg(5'd12, 64'h0000_0000_00A4_3648, "R7");
    check_reg(5'd13, 64'hDEAD_BEEF_CAFE_F00D, "R8");

    // R1: x0 flagged vector still reads zero
    do_op(5'd0, 1'b1, 5'd20, 1'b0, 5'd5, 1'b0, 2'b00, 4'd1, 4'd0, 1'b0, "R1");
    check_reg(5'd5, 64'h0000_0000_1122_3344, "R1");

    // R4 / R5: lane carries and extension
    do_load(5'd1, 64'h0000_0000_0000_70FF);
    do_load(5'd2, 64'h0000_0000_0000_1001);
    do_op(5'd1, 1'b0, 5'd2, 1'b0, 5'd6, 1'b0, 2'b11, 4'd2, 4'd0, 1'b0, "R4");
    check_reg(5'd6, 64'h0000_0000_0000_8000, "R4");
    do_op(5'd1, 1'b0, 5'd2, 1'b0, 5'd6, 1'b0, 2'b11, 4'd0, 4'd0, 1'b0, "R5");
    check_reg(5'd6, 64'h0000_0000_0000_0000, "R5");
    do_load(5'd3, 64'h1111_1111_0000_7000);
    do_load(5'd4, 64'h2222_2222_0000_1000);
    do_op(5'd3, 1'b0, 5'd4, 1'b0, 5'd7, 1'b0, 2'b10, 4'd1, 4'd0, 1'b0, "R5");
    check_reg(5'd7, 64'hFFFF_FFFF_FFFF_8000, "R5");
    do_load(5'd8, 64'h0000_0000_7000_0000);
    do_op(5'd8, 1'b0, 5'd8, 1'b0, 5'd7, 1'b0, 2'b01, 4'd1, 4'd0, 1'b0, "R5");
    check_reg(5'd7, 64'hFFFF_FFFF_E000_0000, "R5");
    do_load(5'd9, 64'hFFFF_FFFF_FFFF_FFFF);
    do_load(5'd10, 64'h0000_0000_0000_0001);
    do_op(5'd9, 1'b0, 5'd10, 1'b0, 5'd7, 1'b0, 2'b00, 4'd1, 4'd0, 1'b0, "R5");
    check_reg(5'd7, 64'd0, "R5");

    // R6: boxing fill
    do_op(5'd3, 1'b0, 5'd4, 1'b0, 5'd7, 1'b0, 2'b10, 4'd1, 4'd0, 1'b1, "R6");
    check_reg(5'd7, 64'hFFFF_FFFF_FFFF_8000, "R6");
    do_op(5'd16, 1'b0, 5'd20, 1'b0, 5'd7, 1'b0, 2'b11, 4'd2, 4'd0, 1'b1, "R6");
    check_reg(5'd7, 64'hFFFF_FFFF_FFFF_3648, "R6");

    // R7: packed 16-bit negative lane, no sign extension
    do_op(5'd3, 1'b0, 5'd4, 1'b0, 5'd7, 1'b0, 2'b10, 4'd2, 4'd0, 1'b0, "R7");
    check_reg(5'd7, 64'h0000_0000_0000_8000, "R7");

    // R8: 32-bit, multiplier 3 capped at two lanes
    do_op(5'd3, 1'b0, 5'd4, 1'b0, 5'd12, 1'b0, 2'b01, 4'd3, 4'd0, 1'b0, "R8");
    check_reg(5'd12, 64'h3333_3333_0000_8000, "R8");
    check_reg(5'd13, 64'hDEAD_BEEF_CAFE_F00D, "R8");

    // R9: vector destination keeps bytes beyond the written elements
    do_load(5'd12, 64'h0123_4567_89AB_CDEF);
    do_op(5'd16, 1'b1, 5'd20, 1'b1, 5'd12, 1'b1, 2'b11, 4'd2, 4'd1, 1'b1, "R9");
    check_reg(5'd12, 64'h0123_4567_89AB_3648, "R9");
    do_op(5'd16, 1'b1, 5'd20, 1'b1, 5'd12, 1'b1, 2'b11, 4'd1, 4'd0, 1'b0, "R9");
    check_reg(5'd12, 64'h0123_4567_89AB_3648, "R9");

    // R11: scalar source broadcast into a vector destination
    do_load(5'd14, 64'd0);
    do_op(5'd16, 1'b0, 5'd20, 1'b1, 5'd14, 1'b1, 2'b11, 4'd1, 4'd4, 1'b0, "R11");
    check_reg(5'd14, 64'h0000_0000_1526_3748, "R11");

    // R2: writes to x0 dropped
    do_op(5'd9, 1'b0, 5'd9, 1'b0, 5'd0, 1'b0, 2'b00, 4'd1, 4'd0, 1'b0, "R2");
    do_load(5'd0, 64'h5555_5555_5555_5555);
    check_reg(5'd0, 64'd0, "R2");

    // R10: load and operation in the same cycle
    @(negedge clk);
    src_a_idx = 5'd9; src_b_idx = 5'd9; dst_idx = 5'd7; dst_vec = 1'b0;
    ew_sel = 2'b00; mul_cnt = 4'd1; box_ones = 1'b0; op_en = 1'b1;
    load_en = 1'b1; load_idx = 5'd8; load_data = 64'h0F0F_0F0F_0F0F_0F0F;
    @(posedge clk);
    @(negedge clk);
    op_en = 1'b0; load_en = 1'b0;
    model[8] = 64'h0F0F_0F0F_0F0F_0F0F;
    check_reg(5'd8, 64'h0F0F_0F0F_0F0F_0F0F, "R10");
    check_reg(5'd7, model[7], "R10");

    // random mix against the model
    for (int i = 1; i < 32; i++) do_load(5'(i), {$urandom, $urandom});
    for (int n = 0; n < 300; n++) begin
      do_op(5'($urandom_range(0, 31)), 1'($urandom), 5'($urandom_range(0, 31)),
            1'($urandom), 5'($urandom_range(0, 31)), 1'($urandom),
            2'($urandom), 4'($urandom_range(0, 9)), 4'($urandom_range(0, 9)),
            1'($urandom), "R4 random");
    end

    // R3: reset mid-run clears everything
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) check_reg(5'(i), 64'd0, "R3");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule